// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date as seven packed-BCD bytes: second, minute, hour (24-hour), day of week, date, month and two-digit year. A single-cycle tick input advances the time by one second. Carries ripple within that same cycle from the seconds up to the year. The block picks the length of the current month by itself, and it gives February 29 days when the year is a multiple of four. That rule stays correct up to the year 2100.

Software or a higher-level controller sets all seven fields at once through a parallel load port. A halt input freezes the count, for example while a host reads a consistent snapshot. The tick normally comes from a one-pulse-per-second prescaler outside the block.

Top module: `bcd_rtc_counter`

## Requirements
- R1: After reset the fields read second 00, minute 00, hour 00, day of week 1, date 01, month 01 and year 00.
- R2: A tick cycle with halt and load low advances the second by one in BCD, 00 to 59, and wraps 59 to 00. The new value shows after the next rising clock edge.
- R3: The minute advances when the second wraps and counts 00 to 59. The hour advances when the minute wraps and counts 00 to 23, wrapping 23 to 00.
- R4: The day of week counts 1 to 7 and wraps to 1. It advances on every date rollover, whatever the date and month are.
- R5: Months 04, 06, 09 and 11 end on date 30. Months 01, 03, 05, 07, 08, 10 and 12 end on date 31. Advancing past the last date sets the date to 01 and advances the month.
- R6: Month 02 ends on date 29 when the year value is divisible by four (00 included), and on 28 otherwise.
- R7: Advancing past date 31 of month 12 sets month 01 and advances the year. Year 99 wraps to 00.
- R8: A load cycle writes all seven fields from the load inputs at the next edge. This happens even when tick or halt is high in the same cycle.
- R9: While halt is high and load is low, ticks are ignored and every field holds its value.
- R10: In a cycle with neither tick nor load, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance pulse |
| halt | input | 1 | Freeze counting |
| load | input | 1 | Parallel load strobe |
| ld_sec | input | 8 | Second to load, BCD |
| ld_min | input | 8 | Minute to load, BCD |
| ld_hour | input | 8 | Hour to load, BCD |
| ld_dow | input | 8 | Day of week to load, 1 to 7 |
| ld_date | input | 8 | Date to load, BCD |
| ld_mon | input | 8 | Month to load, BCD |
| ld_year | input | 8 | Year to load, BCD |
| sec | output | 8 | Current second, BCD |
| min | output | 8 | Current minute, BCD |
| hour | output | 8 | Current hour, BCD |
| dow | output | 8 | Current day of week |
| date | output | 8 | Current date, BCD |
| mon | output | 8 | Current month, BCD |
| year | output | 8 | Current year, BCD |

## Verification
The range assertions assume that every load writes legal BCD within each field's range, including a date no later than that month's last day. The block does not correct an illegal value after it has been loaded. The bench therefore builds every loaded date from the month length its model computes for the loaded month and year, and it draws every other field from its legal range. Halt and tick are driven freely around these loads, so the hold and priority properties see every combination of the three control inputs.

// File: rtl/bcd_rtc_counter.sv
module bcd_rtc_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       halt,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] mon,
  output logic [7:0] year
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic       adv, leap, sec_top, min_top, hour_top, day_end, mon_top;
  logic       c_min, c_hour, c_day, c_mon, c_year;
  logic [7:0] last_day;

  assign adv      = tick & ~halt & ~load;
  assign sec_top  = (sec  == 8'h59);
  assign min_top  = (min  == 8'h59);
  assign hour_top = (hour == 8'h23);
  assign mon_top  = (mon  == 8'h12);

  // a BCD year is a multiple of four when: even tens with ones 0/4/8, odd tens with ones 2/6
  assign leap = year[4] ? (year[3:0] == 4'd2 || year[3:0] == 4'd6)
                        : (year[3:0] == 4'd0 || year[3:0] == 4'd4 || year[3:0] == 4'd8);

  always_comb begin
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign day_end = (date == last_day);
  assign c_min   = adv    & sec_top;
  assign c_hour  = c_min  & min_top;
  assign c_day   = c_hour & hour_top;
  assign c_mon   = c_day  & day_end;
  assign c_year  = c_mon  & mon_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
      dow  <= 8'h01;
      date <= 8'h01;
      mon  <= 8'h01;
      year <= 8'h00;
    end else if (load) begin
      sec  <= ld_sec;
      min  <= ld_min;
      hour <= ld_hour;
      dow  <= ld_dow;
      date <= ld_date;
      mon  <= ld_mon;
      year <= ld_year;
    end else begin
      if (adv)    sec  <= sec_top  ? 8'h00 : bcd_inc(sec);
      if (c_min)  min  <= min_top  ? 8'h00 : bcd_inc(min);
      if (c_hour) hour <= hour_top ? 8'h00 : bcd_inc(hour);
      if (c_day) begin
        dow  <= (dow == 8'h07) ? 8'h01 : dow + 8'h01;
        date <= day_end ? 8'h01 : bcd_inc(date);
      end
      if (c_mon)  mon  <= mon_top  ? 8'h01 : bcd_inc(mon);
      if (c_year) year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end

endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       halt,
  input logic       load,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_min,
  input logic [7:0] ld_hour,
  input logic [7:0] ld_dow,
  input logic [7:0] ld_date,
  input logic [7:0] ld_mon,
  input logic [7:0] ld_year,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] dow,
  input logic [7:0] date,
  input logic [7:0] mon,
  input logic [7:0] year
);

  p_reset_r1: assert property (@(posedge clk) !rst_n |=>
    (sec == 8'h00 && min == 8'h00 && hour == 8'h00 && dow == 8'h01 &&
     date == 8'h01 && mon == 8'h01 && year == 8'h00));

  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[3:0] <= 4'd9 && sec[7:4] <= 4'd5));

  p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hour[3:0] <= 4'd9 && hour <= 8'h23));

  p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt && !load && hour == 8'h23 && min == 8'h59 && sec == 8'h59)
    |=> (hour == 8'h00 && min == 8'h00 && sec == 8'h00));

  p_dow_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dow >= 8'h01 && dow <= 8'h07));

  p_mon_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mon >= 8'h01 && mon <= 8'h12 && mon[3:0] <= 4'd9 && date >= 8'h01 && date <= 8'h31));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec == $past(ld_sec) && min == $past(ld_min) && hour == $past(ld_hour) &&
              dow == $past(ld_dow) && date == $past(ld_date) && mon == $past(ld_mon) &&
              year == $past(ld_year)));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !load) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(dow) &&
                         $stable(date) && $stable(mon) && $stable(year)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(dow) &&
                          $stable(date) && $stable(mon) && $stable(year)));

endmodule

bind bcd_rtc_counter bcd_rtc_checker u_chk (.*);

// File: tb/sim_bcd_rtc_counter.sv
`timescale 1ns/1ps
module sim_bcd_rtc_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, halt = 1'b0, load = 1'b0;
  logic [7:0] ld_sec = 8'h0, ld_min = 8'h0, ld_hour = 8'h0, ld_dow = 8'h1;
  logic [7:0] ld_date = 8'h1, ld_mon = 8'h1, ld_year = 8'h0;
  logic [7:0] sec, min, hour, dow, date, mon, year;

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";
  int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year;

  always #10 clk = ~clk;

  bcd_rtc_counter u0 (.*);

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_date = 1; m_mon = 1; m_year = 0;
    end else if (load) begin
      m_sec = b2i(ld_sec); m_min = b2i(ld_min); m_hour = b2i(ld_hour); m_dow = b2i(ld_dow);
      m_date = b2i(ld_date); m_mon = b2i(ld_mon); m_year = b2i(ld_year);
    end else if (tick && !halt) begin
      m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0; m_hour++;
          if (m_hour == 24) begin
            m_hour = 0;
            m_dow = (m_dow == 7) ? 1 : m_dow + 1;
            if (m_date == mdays(m_mon, m_year)) begin
              m_date = 1; m_mon++;
              if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 100; end
            end else m_date++;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n && !done) begin
      logic [55:0] a, e;
      a = {sec, min, hour, dow, date, mon, year};
      e = {i2b(m_sec), i2b(m_min), i2b(m_hour), i2b(m_dow), i2b(m_date), i2b(m_mon), i2b(m_year)};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s model: actual=%h expected=%h", cur_req, a, e);
      end
    end
  end

  task automatic expect_t(input string req, input logic [55:0] e);
    logic [55:0] a;
    a = {sec, min, hour, dow, date, mon, year};
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic do_load(input logic [7:0] s, mi, h, dw, dt, mo, y, input bit tk, input bit hl);
    @(negedge clk);
    ld_sec = s; ld_min = mi; ld_hour = h; ld_dow = dw; ld_date = dt; ld_mon = mo; ld_year = y;
    load = 1'b1; tick = tk; halt = hl;
    @(negedge clk);
    load = 1'b0; tick = 1'b0; halt = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    expect_t("R1", 56'h00_00_00_01_01_01_00);

    cur_req = "R2";
    ticks(3);
    expect_t("R2", 56'h03_00_00_01_01_01_00);
    @(negedge clk); tick = 1'b1; @(negedge clk); @(negedge clk); tick = 1'b0;
    expect_t("R2", 56'h05_00_00_01_01_01_00);

    cur_req = "R10";
    repeat (5) @(negedge clk);
    expect_t("R10", 56'h05_00_00_01_01_01_00);

    cur_req = "R3";
    do_load(8'h58, 8'h59, 8'h22, 8'h03, 8'h10, 8'h05, 8'h21, 1'b0, 1'b0);
    ticks(2);
    expect_t("R3", 56'h00_00_23_03_10_05_21);
    do_load(8'h59, 8'h59, 8'h23, 8'h03, 8'h10, 8'h05, 8'h21, 1'b0, 1'b0);
    ticks(1);
    expect_t("R3", 56'h00_00_00_04_11_05_21);

    cur_req = "R7";
    do_load(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 1'b0, 1'b0);
    ticks(2);
    expect_t("R7", 56'h00_00_00_01_01_01_00);
    expect_t("R4", 56'h00_00_00_01_01_01_00);

    cur_req = "R5";
    do_load(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h37, 1'b0, 1'b0);
    ticks(1);
    expect_t("R5", 56'h00_00_00_03_01_05_37);
    do_load(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h37, 1'b0, 1'b0);
    ticks(1);
    expect_t("R5", 56'h00_00_00_03_31_01_37);
    do_load(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h11, 8'h37, 1'b0, 1'b0);
    ticks(1);
    expect_t("R5", 56'h00_00_00_06_01_12_37);

    cur_req = "R6";
    do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23, 1'b0, 1'b0);
    ticks(1);
    expect_t("R6", 56'h00_00_00_02_01_03_23);
    do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24, 1'b0, 1'b0);
    ticks(1);
    expect_t("R6", 56'h00_00_00_02_29_02_24);
    do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24, 1'b0, 1'b0);
    ticks(1);
    expect_t("R6", 56'h00_00_00_02_01_03_24);
    do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00, 1'b0, 1'b0);
    ticks(1);
    expect_t("R6", 56'h00_00_00_02_29_02_00);
    do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h30, 1'b0, 1'b0);
    ticks(1);
    expect_t("R6", 56'h00_00_00_02_01_03_30);

    cur_req = "R9";
    do_load(8'h10, 8'h20, 8'h05, 8'h04, 8'h15, 8'h08, 8'h50, 1'b0, 1'b0);
    @(negedge clk); halt = 1'b1; tick = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b0; halt = 1'b0;
    expect_t("R9", 56'h10_20_05_04_15_08_50);

    cur_req = "R8";
    do_load(8'h07, 8'h08, 8'h09, 8'h06, 8'h12, 8'h03, 8'h44, 1'b1, 1'b0);
    expect_t("R8", 56'h07_08_09_06_12_03_44);
    do_load(8'h33, 8'h44, 8'h11, 8'h02, 8'h27, 8'h09, 8'h61, 1'b1, 1'b1);
    expect_t("R8", 56'h33_44_11_02_27_09_61);

    cur_req = "R5";
    for (int it = 0; it < 2000; it++) begin
      int yr, mo, dt, n;
      yr = $urandom_range(0, 99);
      mo = $urandom_range(1, 12);
      dt = ($urandom_range(0, 1) == 1) ? mdays(mo, yr) : $urandom_range(1, mdays(mo, yr));
      do_load(i2b($urandom_range(55, 59)), 8'h59, 8'h23, i2b($urandom_range(1, 7)),
              i2b(dt), i2b(mo), i2b(yr), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      n = $urandom_range(2, 12);
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        tick = 1'($urandom_range(0, 2) != 0);
        halt = ($urandom_range(0, 4) == 0);
      end
      @(negedge clk); tick = 1'b0; halt = 1'b0;
    end

    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule